// File: doc/BRIEF.md
# Dual-Mode Internal Data Memory Controller

This block holds the 256-byte internal data store of an 8-bit microcontroller core and decodes every access into it. A caller presents a byte address with read or write strobes and chooses the kind of access. A plain byte access is either direct or indirect. A register access names R0 to R7 in the bank chosen by a two-bit select. A bit access uses an 8-bit bit address. Which physical location an address reaches depends on the kind of access.

The lower 128 bytes are the same RAM in both direct and indirect mode. The upper 128 addresses split by mode. A direct access there leaves the block on a special-function-register bus. An indirect access there reaches the upper half of the RAM. Bit addresses below 0x80 select one bit in the 16-byte window at 0x20 to 0x2F. Bit addresses from 0x80 upward select one bit of an SFR whose address ends in 0x0 or 0x8. The SFR contents live outside the block. Bit writes to an SFR are done as a read-modify-write over two cycles on that bus.

Top module: `idata_ctrl`

## Requirements
- R1: An indirect byte access (acc_indirect=1, acc_bit=0, acc_reg=0) to any address 0x00-0xFF reads or writes the RAM. Read data appears on rdata with rvalid=1 one cycle after the read strobe. An indirect access never raises sfr_rd or sfr_wr.
- R2: A direct byte access (acc_indirect=0) to an address below 0x80 reaches the same RAM byte as an indirect access to that address.
- R3: A direct byte access to 0x80-0xFF drives sfr_addr with the address, together with sfr_rd or with sfr_wr and sfr_wdata=wdata. The upper RAM is not touched. The SFR read byte, which the bus returns in the cycle after sfr_rd, is presented on rdata with rvalid in that cycle.
- R4: A register access (acc_reg=1, acc_bit=0) reaches byte 8*bank_sel+acc_addr[2:0]. The bank_sel value present at the access is used, so a change of bank affects the very next register access.
- R5: A bit read (acc_bit=1) of a bit address below 0x80 returns bit (a & 7) of RAM byte 0x20+(a>>3) on rdata[0], with rdata[7:1]=0, one cycle after the strobe.
- R6: A bit write of a bit address below 0x80 sets the addressed RAM bit to wdata[0] in the strobe cycle and leaves the other seven bits of that byte unchanged.
- R7: A bit address 0x80-0xFF selects bit (a & 7) of the SFR at (a & 0xF8). A bit read raises sfr_rd and returns the bit on rdata[0]. A bit write raises sfr_rd in the strobe cycle and sfr_wr in the next cycle, writing the read byte with only the addressed bit replaced by wdata[0]. The caller leaves that next cycle idle.
- R8: RAM bit accesses and register accesses raise no SFR strobe. After reset, rvalid, sfr_rd and sfr_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| acc_indirect | input | 1 | 1 = indirect byte access, 0 = direct |
| acc_reg | input | 1 | Register access, acc_addr[2:0] names Rn |
| acc_bit | input | 1 | Bit access, acc_addr is a bit address |
| bank_sel | input | 2 | Register bank select |
| acc_addr | input | 8 | Byte, register or bit address |
| wdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| rdata | output | 8 | Read result (bit result in bit 0) |
| rvalid | output | 1 | rdata valid |
| sfr_addr | output | 8 | SFR bus address |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write byte |
| sfr_rdata | input | 8 | SFR read byte, valid the cycle after sfr_rd |

## Verification
Every read result, whether it comes from RAM, an SFR byte or a single bit, is due exactly one clock after the edge that takes the strobe. The bench drives each access at a falling edge and pushes the expected value into a queue. A monitor samples 2 ns after each rising edge and pops one item whenever rvalid is high. An SFR bit write finishes on the bus one cycle after its strobe, so the bench leaves an idle cycle after every access. It inspects its own SFR model only after that cycle has gone by.

// File: rtl/idata_ctrl.sv
module idata_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          wr,
  input  logic          acc_indirect,
  input  logic          acc_reg,
  input  logic          acc_bit,
  input  logic [1:0]    bank_sel,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [AW-1:0] sfr_addr,
  output logic          sfr_rd,
  output logic          sfr_wr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic [DW-1:0] ram_q;
  logic          sfr_q, bit_q, pend_v, pend_val;
  logic [2:0]    bsel_q, pend_bit;
  logic [AW-1:0] pend_addr;

  wire [2:0]    bsel     = acc_addr[2:0];
  wire [AW-1:0] sfr_base = {acc_addr[AW-1:3], 3'b000};
  wire [AW-1:0] bit_byte = {{(AW-7){1'b0}}, 3'b010, acc_addr[6:3]};
  wire [AW-1:0] reg_byte = {{(AW-5){1'b0}}, bank_sel, bsel};
  wire          hi       = acc_addr[AW-1];

  wire to_sfr = acc_bit ? hi : (!acc_reg && !acc_indirect && hi);
  wire [AW-1:0] ram_addr = acc_bit ? bit_byte : (acc_reg ? reg_byte : acc_addr);
  wire [DW-1:0] ram_cur  = mem[ram_addr];
  wire [DW-1:0] bit_mask = {{(DW-1){1'b0}}, 1'b1} << bsel;
  wire [DW-1:0] ram_bitw = wdata[0] ? (ram_cur | bit_mask) : (ram_cur & ~bit_mask);

  always_ff @(posedge clk)
    if (wr && !to_sfr) mem[ram_addr] <= acc_bit ? ram_bitw : wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rvalid <= 1'b0; sfr_q <= 1'b0; bit_q <= 1'b0; bsel_q <= '0; ram_q <= '0;
      pend_v <= 1'b0; pend_val <= 1'b0; pend_bit <= '0; pend_addr <= '0;
    end else begin
      rvalid <= rd;
      if (rd) begin
        sfr_q  <= to_sfr;
        bit_q  <= acc_bit;
        bsel_q <= bsel;
        if (!to_sfr) ram_q <= ram_cur;
      end
      pend_v <= wr && acc_bit && hi;
      if (wr && acc_bit && hi) begin
        pend_addr <= sfr_base;
        pend_bit  <= bsel;
        pend_val  <= wdata[0];
      end
    end

  wire [DW-1:0] rd_byte  = sfr_q ? sfr_rdata : ram_q;
  wire [DW-1:0] pend_msk = {{(DW-1){1'b0}}, 1'b1} << pend_bit;

  assign rdata     = bit_q ? {{(DW-1){1'b0}}, rd_byte[bsel_q]} : rd_byte;
  assign sfr_rd    = !pend_v && to_sfr && (rd || (wr && acc_bit));
  assign sfr_wr    = pend_v || (wr && to_sfr && !acc_bit);
  assign sfr_addr  = pend_v ? pend_addr : (acc_bit ? sfr_base : acc_addr);
  assign sfr_wdata = pend_v ? (pend_val ? (sfr_rdata | pend_msk) : (sfr_rdata & ~pend_msk)) : wdata;

  assert_rvalid_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  assert_indirect_no_sfr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || wr) && acc_indirect && !acc_bit && !acc_reg && !pend_v) |-> (!sfr_rd && !sfr_wr));
  assert_direct_hi_sfr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || wr) && !acc_indirect && !acc_bit && !acc_reg && hi) |-> ((sfr_rd || sfr_wr) && sfr_addr == acc_addr));
  assert_reg_no_sfr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || wr) && (acc_reg || !hi) && !pend_v) |-> (!sfr_rd && !sfr_wr));
  assert_sfr_rmw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_bit && hi) |=> (sfr_wr && sfr_addr == ($past(acc_addr) & 8'hF8)));
  assert_sfr_rmw_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> (((sfr_wdata ^ sfr_rdata) & ~pend_msk) == '0));
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sfr_rd, sfr_wr}));
endmodule

// File: tb/idata_ctrl_tb.sv
module idata_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic rd = 0, wr = 0, acc_indirect = 0, acc_reg = 0, acc_bit = 0;
  logic [1:0] bank_sel = 0;
  logic [7:0] acc_addr = 0, wdata = 0, rdata, sfr_addr, sfr_wdata;
  logic [7:0] sfr_rdata = 0;
  logic rvalid, sfr_rd, sfr_wr;

  int errors = 0, checks = 0, sfr_wr_cnt = 0, sfr_rd_cnt = 0;
  logic [7:0] ram_m [256];
  logic [7:0] sfr_m [256];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  idata_ctrl u_dut (.clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .acc_indirect(acc_indirect),
    .acc_reg(acc_reg), .acc_bit(acc_bit), .bank_sel(bank_sel), .acc_addr(acc_addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata));

  initial for (int i = 0; i < 256; i++) sfr_m[i] = 8'(i) ^ 8'h5A;
  always @(posedge clk) begin
    if (sfr_wr) begin sfr_m[sfr_addr] <= sfr_wdata; sfr_wr_cnt <= sfr_wr_cnt + 1; end
    if (sfr_rd) begin sfr_rdata <= sfr_m[sfr_addr]; sfr_rd_cnt <= sfr_rd_cnt + 1; end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // mode: 0 indirect, 1 direct, 2 register, 3 bit
  task automatic acc(input logic r, input logic w, input int mode, input logic [1:0] bk,
                     input logic [7:0] a, input logic [7:0] d,
                     input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd = r; wr = w; acc_indirect = (mode == 0); acc_reg = (mode == 2); acc_bit = (mode == 3);
    bank_sel = bk; acc_addr = a; wdata = d;
    if (r) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    rd = 0; wr = 0;
  endtask

  initial forever begin
    @(posedge clk); #2;
    if (rvalid) begin
      if (exp_q.size() == 0) chk("unexpected rvalid", rdata, 8'hxx);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int rc, wc;
    repeat (3) @(negedge clk);
    chk("R8 reset rvalid", {7'b0, rvalid}, 8'h00);
    chk("R8 reset sfr strobes", {6'b0, sfr_rd, sfr_wr}, 8'h00);
    rst_n = 1;
    for (int i = 0; i < 256; i++) begin
      ram_m[i] = 8'(i * 7 + 3);
      acc(0, 1, 0, 0, 8'(i), ram_m[i], 0, "");
    end
    @(negedge clk);
    chk("R1 indirect never strobes SFR", 8'(sfr_wr_cnt + sfr_rd_cnt), 8'h00);
    acc(1, 0, 0, 0, 8'h00, 0, ram_m[8'h00], "R1 ind rd 00");
    acc(1, 0, 0, 0, 8'h7F, 0, ram_m[8'h7F], "R1 ind rd 7F");
    acc(1, 0, 0, 0, 8'h80, 0, ram_m[8'h80], "R1 ind rd 80");
    acc(1, 0, 0, 0, 8'hFF, 0, ram_m[8'hFF], "R1 ind rd FF");
    acc(1, 0, 1, 0, 8'h10, 0, ram_m[8'h10], "R2 dir rd 10");
    acc(1, 0, 1, 0, 8'h7F, 0, ram_m[8'h7F], "R2 dir rd 7F");
    ram_m[8'h40] = 8'hA6;
    acc(0, 1, 1, 0, 8'h40, 8'hA6, 0, "");
    acc(1, 0, 0, 0, 8'h40, 0, ram_m[8'h40], "R2 dir wr seen by ind rd");
    acc(0, 1, 1, 0, 8'h90, 8'hC3, 0, "");
    @(negedge clk);
    chk("R3 dir wr reaches SFR 90", sfr_m[8'h90], 8'hC3);
    acc(1, 0, 0, 0, 8'h90, 0, ram_m[8'h90], "R3 upper RAM 90 untouched");
    acc(1, 0, 1, 0, 8'hA5, 0, sfr_m[8'hA5], "R3 dir rd SFR A5");
    rc = sfr_rd_cnt; wc = sfr_wr_cnt;
    ram_m[8'h15] = 8'h77;
    acc(0, 1, 2, 2'd2, 8'h05, 8'h77, 0, "");
    acc(1, 0, 0, 0, 8'h15, 0, 8'h77, "R4 bank2 R5 at 15");
    acc(1, 0, 2, 2'd3, 8'h00, 0, ram_m[8'h18], "R4 bank3 R0");
    ram_m[8'h01] = 8'h3C;
    acc(0, 1, 2, 2'd0, 8'h01, 8'h3C, 0, "");
    acc(1, 0, 2, 2'd1, 8'h01, 0, ram_m[8'h09], "R4 bank switch next access");
    acc(1, 0, 2, 2'd0, 8'h01, 0, 8'h3C, "R4 bank0 R1");
    acc(1, 0, 3, 0, 8'h00, 0, {7'b0, ram_m[8'h20][0]}, "R5 bit 00");
    acc(1, 0, 3, 0, 8'h7F, 0, {7'b0, ram_m[8'h2F][7]}, "R5 bit 7F");
    acc(1, 0, 3, 0, 8'h3A, 0, {7'b0, ram_m[8'h27][2]}, "R5 bit 3A");
    ram_m[8'h22][3] = ~ram_m[8'h22][3];
    acc(0, 1, 3, 0, 8'h13, {7'b0, ram_m[8'h22][3]}, 0, "");
    acc(1, 0, 0, 0, 8'h22, 0, ram_m[8'h22], "R6 bit write toggles one bit");
    ram_m[8'h2F][7] = 1'b0;
    acc(0, 1, 3, 0, 8'h7F, 8'hFE, 0, "");
    acc(1, 0, 1, 0, 8'h2F, 0, ram_m[8'h2F], "R6 bit clear top bit");
    @(negedge clk);
    chk("R8 RAM/register access no SFR strobe", 8'(sfr_rd_cnt - rc + sfr_wr_cnt - wc), 8'h00);
    acc(1, 0, 3, 0, 8'h8B, 0, {7'b0, sfr_m[8'h88][3]}, "R7 SFR bit 8B");
    acc(1, 0, 3, 0, 8'hFF, 0, {7'b0, sfr_m[8'hF8][7]}, "R7 SFR bit FF");
    begin
      logic [7:0] e;
      e = sfr_m[8'hE0]; e[5] = 1'b1; e[7] = 1'b0;
      acc(0, 1, 3, 0, 8'hE5, 8'h01, 0, "");
      acc(0, 1, 3, 0, 8'hE7, 8'h00, 0, "");
      @(negedge clk);
      chk("R7 SFR RMW merged byte", sfr_m[8'hE0], e);
      acc(1, 0, 1, 0, 8'hE0, 0, e, "R7 dir rd after bit writes");
    end
    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule